// File: doc/BRIEF.md
# CAN FD receive descriptor ring writer

This block takes completed received frames, classic CAN or CAN FD, from the protocol engine one at a time. It stores each frame in a circular ring of 16-byte slots in memory. Memory is written through a plain synchronous port that takes one 64-bit word per cycle. A frame needs a variable number of slots, depending on its decoded payload length. The first 64-bit word of a frame is a header. Its low half carries the identifier, the frame-format flag and the remote flag. Its high half carries the length code, the FD option bits and three status bits. Payload words follow the header. Each payload word wraps to ring offset 0 on its own when it reaches the ring end.

Software owns the read pointer and the ring size. The block owns the write pointer, and it publishes that pointer only after the last word of a frame is in memory. Filling never makes the two pointers equal, so equal pointers always mean the ring is empty. When a frame does not fit, the block drops it and sets a sticky overrun flag. That flag is reported in the next header the block writes, and then cleared.

The controller is a state machine with six states:
- IDLE: waiting, `frm_ready` high. A valid frame is latched and the machine goes to EVAL.
- EVAL: checks the fit. It goes to HEAD if the frame fits, otherwise to DROP.
- DROP: sets the overrun flag and returns to IDLE.
- HEAD: writes the header word. It goes to COMMIT if the frame has no payload, otherwise to DATA.
- DATA: writes one payload word per cycle. After the last payload word it goes to COMMIT.
- COMMIT: advances the write pointer and returns to IDLE.

Top module: `canfd_rx_ring_writer`

## Requirements
- R1: After reset the write and read pointers are 0, the ring size is DEF_SIZE (256 bytes), `frm_ready` is 1, `ring_empty` is 1, `ring_full` is 0 and no memory write is issued.
- R2: Header word 0 (bits 31:0 of the header dword) has bit 31 = extended flag and bit 30 = remote flag. For an extended frame, bit 29 is 0 and bits 28:0 hold the 29-bit identifier. For a standard frame, bits 29:18 hold identifier bits 11:0 and bits 17:0 are 0.
- R3: Header word 1 (bits 63:32 of the header dword) has these fields:
  - DLC in bits 31:28.
  - The three FD option bits in bits 27:25. Option bit 0, at word bit 25, marks an FD frame.
  - Overrun in bit 2, bus-off in bit 1 and error-passive in bit 0.
  - All other bits are 0.
- R4: The payload length is decoded from the DLC as follows. For an FD frame, DLC 0..8 give that many bytes, and DLC 9..15 give 12, 16, 20, 24, 32, 48 and 64 bytes. For a classic frame, a DLC above 8 counts as 8 bytes. The block writes ceil(len/8) payload dwords. Dword k carries input bytes 8k..8k+7, with byte 8k in bits 7:0, copied unchanged.
- R5: The header goes to dword index 2*(wr_ptr/16). After the frame, `wr_ptr` advances by 16*(1+((len+7)>>4)) bytes. If the result reaches the ring size, the ring size is subtracted.
- R6: Payload dword k goes to dword index (2*(wr_ptr/16)+1+k) modulo (ring_size/8). The wrap is independent of the slot boundary.
- R7: A frame is accepted only if its slot count is less than the free slots, where free = size_slots − ((wr − rd) mod size_slots). Otherwise it is dropped: nothing is written to memory and `wr_ptr` is unchanged.
- R8: A drop sets a sticky overrun flag. The next header written carries the flag in word 1 bit 2, and writing that header clears the flag.
- R9: `wr_ptr` stays unchanged while a frame's words are being written. `frm_ready` is low from the cycle after acceptance until processing ends. An accepted frame keeps `frm_ready` low for 3 + ceil(len/8) cycles. A dropped frame keeps it low for 2 cycles.
- R10: A `rd_we` pulse loads `rd_ptr`, ignoring the low 4 bits of the written value. A `size_we` pulse loads the ring size, again ignoring the low 4 bits, and clears both pointers to 0.
- R11: `ring_empty` is 1 exactly when `wr_ptr` equals `rd_ptr`. `ring_full` is 1 exactly when the free slot count is at most 1, so that no frame can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frm_valid | input | 1 | A completed frame is presented |
| frm_ready | output | 1 | Block is idle and latches a presented frame |
| frm_ide | input | 1 | Extended identifier format |
| frm_rtr | input | 1 | Remote request |
| frm_id | input | 29 | Identifier (standard frames use bits 11:0) |
| frm_fdopt | input | 3 | FD option bits; bit 0 marks an FD frame |
| frm_dlc | input | 4 | Data length code |
| frm_busoff | input | 1 | Controller was bus-off for this frame |
| frm_errpas | input | 1 | Controller was error-passive for this frame |
| frm_data | input | 512 | Payload, byte n in bits 8n+7:8n |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | RING_AW-3 | Dword index in the ring |
| mem_wdata | output | 64 | Memory write data |
| rd_we | input | 1 | Load read pointer |
| rd_wdata | input | RING_AW | New read pointer, byte offset |
| size_we | input | 1 | Load ring size, clears pointers |
| size_wdata | input | RING_AW | New ring size in bytes |
| wr_ptr | output | RING_AW | Write pointer, byte offset |
| rd_ptr | output | RING_AW | Read pointer, byte offset |
| ring_size | output | RING_AW | Ring size in bytes |
| ring_empty | output | 1 | Pointers equal |
| ring_full | output | 1 | No frame can fit |

## Verification
A frame is latched at the edge where `frm_valid` and `frm_ready` are both high. The header is written two edges later, and each following payload word one edge after the one before. The new write pointer and a high `frm_ready` appear together, 3 + ceil(len/8) cycles after acceptance. A drop appears after 2 cycles, with no write at all. The bench samples on falling edges. It counts the low-ready cycles of each frame against that figure, and it checks at each of those samples that `wr_ptr` has not moved. It compares memory and pointers only once ready has returned. Register writes take effect at the next edge and are checked on the following falling edge.

// File: rtl/canfd_ring_pkg.sv
package canfd_ring_pkg;

    localparam int CF_DATA_BYTES = 64;
    localparam int CF_DATA_BITS  = CF_DATA_BYTES * 8;
    localparam int CF_ID_BITS    = 29;
    localparam int CF_OPT_BITS   = 3;

    typedef struct packed {
        logic                    ide;
        logic                    rtr;
        logic [CF_ID_BITS-1:0]   id;
        logic [CF_OPT_BITS-1:0]  opt;
        logic [3:0]              dlc;
        logic                    busoff;
        logic                    errpas;
        logic [CF_DATA_BITS-1:0] data;
    } rx_frame_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVAL,
        S_HEAD,
        S_DATA,
        S_COMMIT,
        S_DROP
    } wr_state_t;

    // Payload byte count for a length code; classic frames saturate at 8.
    function automatic logic [6:0] dlc_to_len(input logic [3:0] dlc, input logic fd);
        logic [6:0] len;
        if (dlc <= 4'd8) begin
            len = {3'd0, dlc};
        end else if (!fd) begin
            len = 7'd8;
        end else begin
            case (dlc)
                4'd9:    len = 7'd12;
                4'd10:   len = 7'd16;
                4'd11:   len = 7'd20;
                4'd12:   len = 7'd24;
                4'd13:   len = 7'd32;
                4'd14:   len = 7'd48;
                default: len = 7'd64;
            endcase
        end
        return len;
    endfunction

endpackage

// File: rtl/rxr_len_decode.sv
module rxr_len_decode (
    input  logic [3:0] dlc,
    input  logic       fd,
    output logic [6:0] len,
    output logic [3:0] npay,
    output logic [3:0] slots
);
    import canfd_ring_pkg::*;

    logic [7:0] len_p7;

    always_comb begin
        len    = dlc_to_len(dlc, fd);
        len_p7 = {1'b0, len} + 8'd7;
        npay   = 4'(len_p7 >> 3);
        slots  = 4'(8'd1 + (len_p7 >> 4));
    end
endmodule

// File: rtl/rxr_space.sv
module rxr_space #(
    parameter int SW = 8
) (
    input  logic [SW-1:0] wr_s,
    input  logic [SW-1:0] rd_s,
    input  logic [SW-1:0] size_s,
    input  logic [3:0]    need,
    output logic          fits,
    output logic          empty,
    output logic          full
);
    logic [SW:0] used;
    logic [SW:0] free;

    always_comb begin
        if (wr_s >= rd_s) begin
            used = {1'b0, wr_s} - {1'b0, rd_s};
        end else begin
            used = {1'b0, wr_s} + {1'b0, size_s} - {1'b0, rd_s};
        end
        free  = {1'b0, size_s} - used;
        fits  = (SW+1)'(need) < free;
        empty = (wr_s == rd_s);
        full  = free <= (SW+1)'(1);
    end
endmodule

// File: rtl/canfd_rx_ring_writer.sv
module canfd_rx_ring_writer #(
    parameter int RING_AW  = 12,
    parameter int DEF_SIZE = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_valid,
    output logic               frm_ready,
    input  logic               frm_ide,
    input  logic               frm_rtr,
    input  logic [28:0]        frm_id,
    input  logic [2:0]         frm_fdopt,
    input  logic [3:0]         frm_dlc,
    input  logic               frm_busoff,
    input  logic               frm_errpas,
    input  logic [511:0]       frm_data,
    output logic               mem_we,
    output logic [RING_AW-4:0] mem_addr,
    output logic [63:0]        mem_wdata,
    input  logic               rd_we,
    input  logic [RING_AW-1:0] rd_wdata,
    input  logic               size_we,
    input  logic [RING_AW-1:0] size_wdata,
    output logic [RING_AW-1:0] wr_ptr,
    output logic [RING_AW-1:0] rd_ptr,
    output logic [RING_AW-1:0] ring_size,
    output logic               ring_empty,
    output logic               ring_full
);
    import canfd_ring_pkg::*;

    localparam int SW   = RING_AW - 4;
    localparam int DW_W = RING_AW - 3;

    wr_state_t         state, state_d;
    rx_frame_t         frm_q;
    logic [SW-1:0]     wr_s, rd_s, size_s;
    logic [DW_W-1:0]   dw_addr_q;
    logic [3:0]        pay_idx_q;
    logic              ovr_q;

    logic [6:0]        len;
    logic [3:0]        npay, slots;
    logic              fits;
    logic [SW:0]       wr_sum;
    logic [SW-1:0]     wr_nxt;
    logic [DW_W-1:0]   size_dw, hdr_addr, hdr_inc, dat_inc;
    logic [31:0]       hw0, hw1;
    logic [63:0]       pay_word;

    rxr_len_decode u_len (
        .dlc   (frm_q.dlc),
        .fd    (frm_q.opt[0]),
        .len   (len),
        .npay  (npay),
        .slots (slots)
    );

    rxr_space #(.SW(SW)) u_space (
        .wr_s   (wr_s),
        .rd_s   (rd_s),
        .size_s (size_s),
        .need   (slots),
        .fits   (fits),
        .empty  (ring_empty),
        .full   (ring_full)
    );

    // Address arithmetic in dword and slot units
    always_comb begin
        size_dw  = {size_s, 1'b0};
        hdr_addr = {wr_s, 1'b0};
        hdr_inc  = (hdr_addr + DW_W'(1) == size_dw) ? '0 : hdr_addr + DW_W'(1);
        dat_inc  = (dw_addr_q + DW_W'(1) == size_dw) ? '0 : dw_addr_q + DW_W'(1);
        wr_sum   = {1'b0, wr_s} + (SW+1)'(slots);
        wr_nxt   = (wr_sum >= {1'b0, size_s}) ? SW'(wr_sum - {1'b0, size_s}) : SW'(wr_sum);
    end

    // Header and payload words
    always_comb begin
        if (frm_q.ide) begin
            hw0 = {1'b1, frm_q.rtr, 1'b0, frm_q.id};
        end else begin
            hw0 = {1'b0, frm_q.rtr, frm_q.id[11:0], 18'd0};
        end
        hw1      = {frm_q.dlc, frm_q.opt, 22'd0, ovr_q, frm_q.busoff, frm_q.errpas};
        pay_word = frm_q.data[{pay_idx_q[2:0], 6'd0} +: 64];
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:   if (frm_valid) state_d = S_EVAL;
            S_EVAL:   state_d = fits ? S_HEAD : S_DROP;
            S_HEAD:   state_d = (npay == 4'd0) ? S_COMMIT : S_DATA;
            S_DATA:   if (pay_idx_q == npay - 4'd1) state_d = S_COMMIT;
            S_COMMIT: state_d = S_IDLE;
            S_DROP:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_d;
    end

    // Outputs
    always_comb begin
        frm_ready = (state == S_IDLE);
        mem_we    = (state == S_HEAD) || (state == S_DATA);
        mem_addr  = (state == S_HEAD) ? hdr_addr : dw_addr_q;
        mem_wdata = (state == S_HEAD) ? {hw1, hw0} : pay_word;
        wr_ptr    = {wr_s, 4'd0};
        rd_ptr    = {rd_s, 4'd0};
        ring_size = {size_s, 4'd0};
    end

    // Datapath and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q     <= '0;
            wr_s      <= '0;
            rd_s      <= '0;
            size_s    <= SW'(DEF_SIZE / 16);
            dw_addr_q <= '0;
            pay_idx_q <= '0;
            ovr_q     <= 1'b0;
        end else begin
            if (state == S_IDLE && frm_valid) begin
                frm_q <= '{ide: frm_ide, rtr: frm_rtr, id: frm_id, opt: frm_fdopt,
                           dlc: frm_dlc, busoff: frm_busoff, errpas: frm_errpas,
                           data: frm_data};
            end
            if (state == S_HEAD) begin
                dw_addr_q <= hdr_inc;
                pay_idx_q <= '0;
                ovr_q     <= 1'b0;
            end
            if (state == S_DATA) begin
                dw_addr_q <= dat_inc;
                pay_idx_q <= pay_idx_q + 4'd1;
            end
            if (state == S_DROP) ovr_q <= 1'b1;
            if (state == S_COMMIT) wr_s <= wr_nxt;
            if (rd_we) rd_s <= SW'(rd_wdata >> 4);
            if (size_we) begin
                size_s <= SW'(size_wdata >> 4);
                wr_s   <= '0;
                rd_s   <= '0;
            end
        end
    end

    // R9
    wr_publish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_s) |-> ($past(state) == S_COMMIT || $past(size_we)));

    // R9
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !frm_ready);

    // R7
    no_equal_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMMIT && !rd_we && !size_we) |=> !ring_empty);

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && size_s != '0) |-> mem_addr < size_dw);

    // R8
    ovr_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_q) |-> ($past(state) == S_HEAD && $past(mem_wdata[34])));

    // R11
    flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_empty && size_s >= SW'(2)) |-> !ring_full);

endmodule

// File: tb/canfd_rx_ring_writer_tb.sv
module canfd_rx_ring_writer_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frm_valid = 1'b0;
    logic         frm_ready;
    logic         frm_ide = 1'b0, frm_rtr = 1'b0;
    logic [28:0]  frm_id = '0;
    logic [2:0]   frm_fdopt = '0;
    logic [3:0]   frm_dlc = '0;
    logic         frm_busoff = 1'b0, frm_errpas = 1'b0;
    logic [511:0] frm_data = '0;
    logic         mem_we;
    logic [8:0]   mem_addr;
    logic [63:0]  mem_wdata;
    logic         rd_we = 1'b0, size_we = 1'b0;
    logic [11:0]  rd_wdata = '0, size_wdata = '0;
    logic [11:0]  wr_ptr, rd_ptr, ring_size;
    logic         ring_empty, ring_full;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    int idx = 0;
    logic [63:0] bmem [0:511];

    // model state, slot units
    int m_wr = 0, m_rd = 0, m_size = 16;
    logic m_ovr = 1'b0;

    canfd_rx_ring_writer u_dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_ide(frm_ide), .frm_rtr(frm_rtr), .frm_id(frm_id), .frm_fdopt(frm_fdopt),
        .frm_dlc(frm_dlc), .frm_busoff(frm_busoff), .frm_errpas(frm_errpas),
        .frm_data(frm_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rd_we(rd_we), .rd_wdata(rd_wdata), .size_we(size_we), .size_wdata(size_wdata),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .ring_size(ring_size),
        .ring_empty(ring_empty), .ring_full(ring_full)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
            wcount <= wcount + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [3:0] dlc, input logic fd);
        int tbl [16] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 12, 16, 20, 24, 32, 48, 64};
        if (fd) return tbl[dlc];
        return (dlc > 8) ? 8 : int'(dlc);
    endfunction

    function automatic int m_free();
        return m_size - ((m_wr - m_rd + m_size) % m_size);
    endfunction

    task automatic check_flags();
        chk("R11 empty", {63'd0, ring_empty}, {63'd0, m_wr == m_rd});
        chk("R11 full", {63'd0, ring_full}, {63'd0, m_free() <= 1});
    endtask

    task automatic set_rd(input int bytes);
        @(negedge clk);
        rd_we = 1'b1;
        rd_wdata = 12'(bytes);
        @(negedge clk);
        rd_we = 1'b0;
        m_rd = bytes / 16;
        chk("R10 rd_ptr", {52'd0, rd_ptr}, 64'(m_rd * 16));
    endtask

    task automatic set_size(input int bytes);
        @(negedge clk);
        size_we = 1'b1;
        size_wdata = 12'(bytes);
        @(negedge clk);
        size_we = 1'b0;
        m_size = bytes / 16;
        m_wr = 0;
        m_rd = 0;
        chk("R10 size", {52'd0, ring_size}, 64'(m_size * 16));
        chk("R10 wr clr", {52'd0, wr_ptr}, 64'd0);
        chk("R10 rd clr", {52'd0, rd_ptr}, 64'd0);
    endtask

    task automatic send(input logic ide, input logic rtr, input logic [28:0] id,
                        input logic [2:0] fo, input logic [3:0] dlc,
                        input logic bo, input logic ep);
        int len, npay, slots, busy, hdr;
        logic ok;
        logic [31:0] w0, w1;
        logic [11:0] old_wr;
        len   = exp_len(dlc, fo[0]);
        npay  = (len + 7) / 8;
        slots = 1 + ((len + 7) >> 4);
        ok    = slots < m_free();
        @(negedge clk);
        frm_ide = ide; frm_rtr = rtr; frm_id = id; frm_fdopt = fo; frm_dlc = dlc;
        frm_busoff = bo; frm_errpas = ep;
        for (int b = 0; b < 64; b++) frm_data[b*8 +: 8] = 8'(idx * 29 + b * 7 + 3);
        frm_valid = 1'b1;
        old_wr = wr_ptr;
        chk("R9 ready idle", {63'd0, frm_ready}, 64'd1);
        wcount = 0;
        @(negedge clk);
        frm_valid = 1'b0;
        busy = 0;
        while (!frm_ready && busy < 40) begin
            busy++;
            chk("R9 wr stable", {52'd0, wr_ptr}, {52'd0, old_wr});
            @(negedge clk);
        end
        chk("R9 busy cycles", 64'(busy), 64'(ok ? 3 + npay : 2));
        chk("R7 write count", 64'(wcount), 64'(ok ? 1 + npay : 0));
        if (ok) begin
            w0 = ide ? {1'b1, rtr, 1'b0, id} : {1'b0, rtr, id[11:0], 18'd0};
            w1 = {dlc, fo, 22'd0, m_ovr, bo, ep};
            hdr = m_wr * 2;
            chk("R2 R3 header", bmem[hdr], {w1, w0});
            for (int k = 0; k < npay; k++)
                chk("R4 R6 payload", bmem[(hdr + 1 + k) % (m_size * 2)], frm_data[k*64 +: 64]);
            m_wr = (m_wr + slots) % m_size;
            m_ovr = 1'b0;
            chk("R5 wr advance", {52'd0, wr_ptr}, 64'(m_wr * 16));
        end else begin
            m_ovr = 1'b1;
            chk("R7 drop wr", {52'd0, wr_ptr}, {52'd0, old_wr});
        end
        check_flags();
        idx++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) bmem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 wr", {52'd0, wr_ptr}, 64'd0);
        chk("R1 rd", {52'd0, rd_ptr}, 64'd0);
        chk("R1 size", {52'd0, ring_size}, 64'd256);
        chk("R1 ready", {63'd0, frm_ready}, 64'd1);
        chk("R1 mem_we", {63'd0, mem_we}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 empty", {63'd0, ring_empty}, 64'd1);
        chk("R1 full", {63'd0, ring_full}, 64'd0);

        // sweep all length codes in both formats; drain on every third frame
        for (int fd = 0; fd < 2; fd++) begin
            for (int d = 0; d < 16; d++) begin
                send(d[0], d[1] ^ fd[0], 29'(32'h1234567 + d * 32'h0101_0305),
                     {d[2], d[3], fd[0]}, 4'(d), d[2], d[3]);
                if (idx % 3 == 0) set_rd(m_wr * 16 + 7);
            end
        end
        set_rd(m_wr * 16);

        // fill with 64-byte frames until drops, then report overrun
        for (int i = 0; i < 5; i++) send(1'b1, 1'b0, 29'(i), 3'b001, 4'd15, 1'b0, 1'b0);
        chk("R11 full after fill", {63'd0, ring_full}, 64'd1);
        set_rd(m_wr * 16);
        send(1'b0, 1'b0, 29'h7ff, 3'b000, 4'd2, 1'b0, 1'b0);
        chk("R8 ovr reported", bmem[((m_wr - 1 + m_size) % m_size) * 2][34], 64'd1);
        send(1'b0, 1'b1, 29'h123, 3'b000, 4'd1, 1'b0, 1'b1);
        chk("R8 ovr cleared", bmem[((m_wr - 1 + m_size) % m_size) * 2][34], 64'd0);

        // small ring: payload words wrap past the end independently
        set_size(96 + 5);
        for (int r = 0; r < 3; r++) begin
            for (int d = 8; d < 16; d++) begin
                send(r[0], 1'b0, 29'(d * 77), 3'b001, 4'(d), 1'b1, 1'b0);
                set_rd(m_wr * 16);
            end
        end
        set_size(256);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule